// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits inside one multiprocessor and decides which warp issues on each cycle. A thread block that becomes resident asks for warp slots. Its thread count is rounded up to whole 32-thread warps. The block receives a run of neighbouring free slots, and each of those slots records the identifier of its block. The request is refused when no such run exists. From then on, an external dependency tracker raises a per-slot ready bit whenever the operands of that warp's next instruction are available.

On every cycle the scheduler looks at the slots that are both resident and ready, and it grants the one with the lowest index. It reports that slot number and its owning block so that the front end can issue one instruction to all threads of that warp. The choice is made afresh every cycle, so consecutive cycles may issue from different warps with no dead cycle between them. When nothing is eligible, an idle flag marks a bubble. A retire request frees a slot so that a later block can reuse it.

Top module: `warp_scheduler`

## Requirements
- R1: After reset no slot is resident: issue_valid is 0 and idle is 1 whatever ready_mask holds.
- R2: An allocation of N threads needs ceil(N/32) warps. It is accepted in the same cycle when that many adjacent free slots exist. alloc_base is the lowest start index of such a run. From the next cycle those slots are resident and carry alloc_block.
- R3: A request with N = 0, or one for which no long enough run of free slots exists, is refused (alloc_accept = 0) and leaves every slot unchanged.
- R4: issue_valid is 1 exactly when some resident slot has its ready_mask bit set. issue_warp is then the lowest such slot index and issue_block is that slot's block identifier, all in the same cycle as ready_mask.
- R5: ready_mask bits of slots that are not resident have no effect on the issue outputs.
- R6: idle equals the inverse of issue_valid. While idle, issue_warp and issue_block are both 0.
- R7: retire_valid frees slot retire_warp from the next cycle onward, and the slot can then be allocated again. Retiring a slot that is already free changes nothing.
- R8: The selection costs no dead cycles. Different warps can issue on back-to-back cycles, each following that cycle's ready_mask.
- R9: An allocation and a retire presented in the same cycle do not interact. The allocation treats the slot being retired as still occupied.
- R10: While alloc_valid is 0, alloc_accept is 0 and no slot is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | A block asks for warp slots this cycle |
| alloc_threads | input | 10 | Thread count of the requesting block |
| alloc_block | input | 4 | Identifier of the requesting block |
| alloc_accept | output | 1 | Request granted this cycle |
| alloc_base | output | 5 | First slot of the granted run |
| ready_mask | input | 24 | Per-slot operand-ready bits |
| retire_valid | input | 1 | Free one slot this cycle |
| retire_warp | input | 5 | Slot to free |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | 5 | Slot index of the issuing warp |
| issue_block | output | 4 | Block owning the issuing warp |
| idle | output | 1 | No eligible warp, bubble cycle |

## Verification
A corrupted resident bit or block tag shows up on the issue outputs in the first cycle in which that slot's ready bit is raised. It appears as a warp that never issues, a bubble where a grant was due, or the wrong block identifier. A wrong free-run search shows at once as a wrong alloc_base or acceptance decision. It also shows one cycle later through the slots that the issue port reports. Masking ready bits one slot at a time turns each hidden slot state into a port value within a single cycle.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int unsigned DEF_NUM_WARPS = 24;
  localparam int unsigned DEF_WARP_SIZE = 32;
  localparam int unsigned DEF_BID_W     = 4;
endpackage

// File: rtl/wsched_prio_pick.sv
module wsched_prio_pick #(
  parameter  int WIDTH = 24,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // lowest set bit wins; scanning downward lets the last hit stand
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (req[idx] && ((req & ~({WIDTH{1'b1}} << idx)) == '0))); // R4

endmodule

// File: rtl/wsched_alloc.sv
module wsched_alloc #(
  parameter int NUM_WARPS = 24,
  parameter int WARP_SIZE = 32,
  parameter int THR_W     = 10,
  parameter int WID_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [THR_W-1:0]     alloc_threads,
  input  logic [NUM_WARPS-1:0] free_mask,
  output logic                 accept,
  output logic [WID_W-1:0]     base,
  output logic [NUM_WARPS-1:0] grant
);

  localparam int LOG_WS = $clog2(WARP_SIZE);
  localparam int CNT_W  = THR_W + 1;

  logic [CNT_W-1:0]       need;
  logic                   size_ok;
  logic [2*NUM_WARPS-1:0] free_ext;
  logic [NUM_WARPS-1:0]   fit;
  logic                   any_fit;

  // round the thread count up to whole warps
  always_comb begin
    need    = (CNT_W'(alloc_threads) + CNT_W'(WARP_SIZE - 1)) >> LOG_WS;
    size_ok = (need != '0) && (need <= CNT_W'(NUM_WARPS));
  end

  // slots past the top read as occupied so runs cannot wrap
  assign free_ext = {{NUM_WARPS{1'b0}}, free_mask};

  always_comb begin
    for (int b = 0; b < NUM_WARPS; b++) begin
      fit[b] = size_ok;
      for (int o = 0; o < NUM_WARPS; o++) begin
        if ((CNT_W'(o) < need) && !free_ext[b + o]) fit[b] = 1'b0;
      end
    end
  end

  wsched_prio_pick #(.WIDTH(NUM_WARPS)) u_base_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (fit),
    .found (any_fit),
    .idx   (base)
  );

  assign accept = alloc_valid && any_fit;

  always_comb begin
    for (int i = 0; i < NUM_WARPS; i++) begin
      grant[i] = accept && (i >= int'(base)) && ((i - int'(base)) < int'(need));
    end
  end

  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (((grant & ~free_mask) == '0) && ($countones(grant) == int'(need)))); // R2
  AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && (alloc_threads == '0)) |-> (!accept && (grant == '0))); // R3
  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_valid |-> (grant == '0)); // R10

endmodule

// File: rtl/wsched_slot_table.sv
module wsched_slot_table #(
  parameter int NUM_WARPS = 24,
  parameter int BID_W     = 4,
  parameter int WID_W     = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_WARPS-1:0]             grant,
  input  logic [BID_W-1:0]                 alloc_block,
  input  logic                             retire_valid,
  input  logic [WID_W-1:0]                 retire_warp,
  output logic [NUM_WARPS-1:0]             valid,
  output logic [NUM_WARPS-1:0][BID_W-1:0]  blk
);

  logic [NUM_WARPS-1:0]            valid_q;
  logic [NUM_WARPS-1:0]            valid_d;
  logic [NUM_WARPS-1:0][BID_W-1:0] blk_q;
  logic                            retire_ok;

  assign retire_ok = retire_valid && (int'(retire_warp) < NUM_WARPS);

  always_comb begin
    valid_d = valid_q;
    if (retire_ok) valid_d[retire_warp] = 1'b0;
    valid_d = valid_d | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        blk_q[g] <= '0;
      else if (grant[g]) blk_q[g] <= alloc_block;
    end
  end

  assign valid = valid_q;
  assign blk   = blk_q;

  AST_GRANT_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & valid_q) == '0); // R9
  AST_GRANT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((valid_q & $past(grant)) == $past(grant))); // R2
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ok |=> !valid_q[$past(retire_warp)]); // R7

endmodule

// File: rtl/warp_scheduler.sv
module warp_scheduler
  import wsched_pkg::*;
#(
  parameter  int NUM_WARPS = DEF_NUM_WARPS,
  parameter  int WARP_SIZE = DEF_WARP_SIZE,
  parameter  int BID_W     = DEF_BID_W,
  localparam int WID_W     = $clog2(NUM_WARPS),
  localparam int THR_W     = $clog2(NUM_WARPS * WARP_SIZE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [THR_W-1:0]     alloc_threads,
  input  logic [BID_W-1:0]     alloc_block,
  output logic                 alloc_accept,
  output logic [WID_W-1:0]     alloc_base,
  input  logic [NUM_WARPS-1:0] ready_mask,
  input  logic                 retire_valid,
  input  logic [WID_W-1:0]     retire_warp,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic [BID_W-1:0]     issue_block,
  output logic                 idle
);

  logic [NUM_WARPS-1:0]            valid;
  logic [NUM_WARPS-1:0][BID_W-1:0] blk;
  logic [NUM_WARPS-1:0]            grant;
  logic [NUM_WARPS-1:0]            eligible;

  wsched_alloc #(
    .NUM_WARPS (NUM_WARPS),
    .WARP_SIZE (WARP_SIZE),
    .THR_W     (THR_W),
    .WID_W     (WID_W)
  ) u_alloc (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .alloc_threads (alloc_threads),
    .free_mask     (~valid),
    .accept        (alloc_accept),
    .base          (alloc_base),
    .grant         (grant)
  );

  wsched_slot_table #(
    .NUM_WARPS (NUM_WARPS),
    .BID_W     (BID_W),
    .WID_W     (WID_W)
  ) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant        (grant),
    .alloc_block  (alloc_block),
    .retire_valid (retire_valid),
    .retire_warp  (retire_warp),
    .valid        (valid),
    .blk          (blk)
  );

  assign eligible = valid & ready_mask;

  wsched_prio_pick #(.WIDTH(NUM_WARPS)) u_issue_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (eligible),
    .found (issue_valid),
    .idx   (issue_warp)
  );

  assign issue_block = issue_valid ? blk[issue_warp] : '0;
  assign idle        = !issue_valid;

  AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (valid[issue_warp] && ready_mask[issue_warp])); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> ((issue_warp == '0) && (issue_block == '0))); // R6
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> idle); // R1

endmodule

// File: tb/tb_warp_scheduler.sv
`timescale 1ns/1ps
module tb_warp_scheduler;

  logic        clk;
  logic        rst_n;
  logic        alloc_valid;
  logic [9:0]  alloc_threads;
  logic [3:0]  alloc_block;
  logic        alloc_accept;
  logic [4:0]  alloc_base;
  logic [23:0] ready_mask;
  logic        retire_valid;
  logic [4:0]  retire_warp;
  logic        issue_valid;
  logic [4:0]  issue_warp;
  logic [3:0]  issue_block;
  logic        idle;

  int checks = 0;
  int fails  = 0;

  warp_scheduler dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_threads(alloc_threads), .alloc_block(alloc_block),
    .alloc_accept(alloc_accept), .alloc_base(alloc_base),
    .ready_mask(ready_mask), .retire_valid(retire_valid), .retire_warp(retire_warp),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_block(issue_block), .idle(idle)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {mask[33:10], valid[9], warp[8:4], block[3:0]}; resident: 0-7 blk3, 8-11 blk5, 12-13 blk9
  localparam logic [33:0] VEC [8] = '{
    {24'h000000, 1'b0, 5'd0,  4'd0},   // R6 nothing ready
    {24'hFFFFFF, 1'b1, 5'd0,  4'd3},   // R4 lowest wins
    {24'h000100, 1'b1, 5'd8,  4'd5},   // R8 switch next cycle
    {24'hFFC000, 1'b0, 5'd0,  4'd0},   // R5 free slots ignored
    {24'h002000, 1'b1, 5'd13, 4'd9},
    {24'h003080, 1'b1, 5'd7,  4'd3},
    {24'h000C00, 1'b1, 5'd10, 4'd5},
    {24'h001000, 1'b1, 5'd12, 4'd9}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue_chk(input logic [23:0] m, input int v, input int w, input int b,
                           input string tag);
    @(negedge clk);
    ready_mask = m;
    #1;
    chk({tag, " issue_valid"}, int'(issue_valid), v);
    chk({tag, " idle"},        int'(idle),        1 - v);
    chk({tag, " issue_warp"},  int'(issue_warp),  w);
    chk({tag, " issue_block"}, int'(issue_block), b);
  endtask

  task automatic alloc(input int thr, input int bid, input bit rv, input int rw,
                       input int exp_acc, input int exp_base, input string tag);
    @(negedge clk);
    alloc_valid   = 1'b1;
    alloc_threads = 10'(thr);
    alloc_block   = 4'(bid);
    retire_valid  = rv;
    retire_warp   = 5'(rw);
    #1;
    chk({tag, " alloc_accept"}, int'(alloc_accept), exp_acc);
    if (exp_acc != 0) chk({tag, " alloc_base"}, int'(alloc_base), exp_base);
    @(negedge clk);
    alloc_valid  = 1'b0;
    retire_valid = 1'b0;
  endtask

  task automatic retire(input int w);
    @(negedge clk);
    retire_valid = 1'b1;
    retire_warp  = 5'(w);
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_threads = '0; alloc_block = '0;
    ready_mask = '0; retire_valid = 1'b0; retire_warp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    issue_chk(24'hFFFFFF, 0, 0, 0, "R1 reset");

    alloc(256, 3, 1'b0, 0, 1, 0,  "R2 blkA");
    alloc(100, 5, 1'b0, 0, 1, 8,  "R2 blkB round up");
    alloc(33,  9, 1'b0, 0, 1, 12, "R2 blkC round up");

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ready_mask = VEC[i][33:10];
      #1;
      chk($sformatf("R4/R8 vec%0d issue_valid", i), int'(issue_valid), int'(VEC[i][9]));
      chk($sformatf("R6 vec%0d idle", i), int'(idle), 1 - int'(VEC[i][9]));
      chk($sformatf("R4/R8 vec%0d issue_warp", i), int'(issue_warp), int'(VEC[i][8:4]));
      chk($sformatf("R4 vec%0d issue_block", i), int'(issue_block), int'(VEC[i][3:0]));
    end

    alloc(400, 1, 1'b0, 0, 0, 0, "R3 no room");
    alloc(0,   1, 1'b0, 0, 0, 0, "R3 zero threads");
    issue_chk(24'hFFC000, 0, 0, 0, "R3 state unchanged");

    @(negedge clk);
    alloc_valid = 1'b0; alloc_threads = 10'd32; alloc_block = 4'd6;
    #1;
    chk("R10 no request accept", int'(alloc_accept), 0);
    issue_chk(24'hFFC000, 0, 0, 0, "R10 nothing allocated");

    for (int w = 8; w < 12; w++) retire(w);
    issue_chk(24'h000F00, 0, 0, 0, "R7 retired idle");
    retire(20);
    issue_chk(24'h100000, 0, 0, 0, "R7 free retire no effect");
    issue_chk(24'hFFFFFF, 1, 0, 3, "R7 others kept");

    alloc(128, 7, 1'b0, 0, 1, 8, "R7 reuse");
    issue_chk(24'h000100, 1, 8, 7, "R7 reused slot");

    alloc(352, 2, 1'b1, 13, 0, 0, "R9 same-cycle retire");
    alloc(352, 2, 1'b0, 0, 1, 13, "R9 after retire");
    issue_chk(24'h800000, 1, 23, 2, "R9 top slot");
    issue_chk(24'h002000, 1, 13, 2, "R9 retag");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule